// File: doc/BRIEF.md
# Protection-Table Cache Range Invalidator

This block holds a small fully associative cache of protection-table entries. Each entry carries a physical address tag and the walk level it was fetched from, and the level fixes how large a region the entry covers. A separate fill port loads entries one at a time. On a 64-bit range-invalidate command the unit decodes an effective base address and an effective range length. The decode depends on the configured physical granule, the wide-address enable and the implemented physical address width. The unit then sweeps the cache one entry per clock and clears every valid entry whose region overlaps the range.

Commands are taken with a valid/ready handshake and the configuration inputs are sampled in the same cycle. A request that is malformed still completes, but it changes nothing. This covers a reserved size code, a reserved granule, a misaligned base and a base beyond the implemented address width. A request issued below the top privilege level raises an undefined-instruction flag together with its completion pulse.

Top module: `prot_cache_rinv`

## Requirements
- R1: While reset is held, `done` and `undef` are 0, `ent_valid` is all zeros and `cmd_ready` is 1.
- R2: A fill (`fill_en` high while `cmd_ready` is high) writes the tag and level into slot `fill_idx`, and that slot's `ent_valid` bit reads 1 after the next clock edge.
- R3: While a sweep is running, `cmd_ready` is 0 and a fill request is ignored, so no `ent_valid` bit rises during a sweep.
- R4: A legal request keeps `cmd_ready` low for its sweep. `done` pulses for one cycle, becoming visible N_ENT+1 clock edges after the accepting edge. `ent_valid` shows the final state in that same cycle.
- R5: The base address is built from operand bits 39:0 placed at address bit 12 upward. Granule code 2'b00 (4KB) keeps all of them. Code 2'b10 (16KB) forces operand bits 1:0 to zero, and code 2'b01 (64KB) forces operand bits 3:0 to zero. Address bits 11:0 are zero.
- R6: The size code sits in operand bits 47:44. Codes 0 to 9 give ranges of 2^12, 2^14, 2^16, 2^21, 2^25, 2^29, 2^30, 2^34, 2^36 and 2^39 bytes. A range smaller than the granule is widened to the granule.
- R7: A valid entry is cleared when its region overlaps [base, base+range-1]. A level-0 entry covers the aligned 2^30 bytes around its tag and a level-1 entry covers 2^21 bytes. Level-2 and level-3 entries cover 2^12 bytes. This applies to entries of every level.
- R8: With `cfg_wide` high, operand bits 43:40 become address bits 55:52; with it low they are ignored. Operand bits 63:48 are always ignored.
- R9: Size codes 10 to 15 or granule code 2'b11 make the request a no-op. `done` is visible right after the accepting edge and no entry changes.
- R10: A base that is not a multiple of the effective range makes the request a no-op, completing as in R9.
- R11: A base at or above 2^`cfg_pa_bits` (when `cfg_pa_bits` < 56) makes the request a no-op, completing as in R9.
- R12: A request with `cfg_el` other than 2'b11 clears nothing. `undef` and `done` are both high right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Range-invalidate request |
| cmd_ready | output | 1 | Unit idle and able to take a request |
| cmd_operand | input | 64 | Range-invalidate operand |
| cfg_granule | input | 2 | Physical granule code |
| cfg_pa_bits | input | 6 | Implemented physical address width in bits |
| cfg_el | input | 2 | Privilege level of the requester |
| cfg_wide | input | 1 | Use operand bits 43:40 as address bits 55:52 |
| fill_en | input | 1 | Write one cache entry |
| fill_idx | input | IW | Slot to write |
| fill_addr | input | PA_W | Physical address tag of the entry |
| fill_level | input | 2 | Walk level of the entry |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Request refused for privilege |
| ent_valid | output | N_ENT | Valid bit of each slot |

## Verification
On every cycle the assertions check the following. A fill accepted while idle sets its slot. No valid bit rises while a sweep is running. A legal request drops `cmd_ready`, and a no-op request completes at once with the slot state unchanged. A privilege refusal always raises `undef` together with `done`, and `done` never lasts two cycles without a new request. The bench scenarios are needed to show that the right entries are cleared. That covers how the base is rebuilt for each granule and how the size is clamped. It also covers the level-dependent overlap rule, the wide-address bits, and the exact edge on which a full sweep ends.

// File: rtl/pcri_pkg.sv
package pcri_pkg;
  localparam int OP_SIZE_LSB = 44;
  localparam int OP_HI_LSB   = 40;
  localparam int OP_ADDR_W   = 40;
  localparam int PAGE_SH     = 12;
  localparam logic [1:0] EL_TOP = 2'b11;

  typedef enum logic [1:0] {
    GRAN_4K  = 2'b00,
    GRAN_64K = 2'b01,
    GRAN_16K = 2'b10,
    GRAN_BAD = 2'b11
  } gran_e;

  // log2 of the range selected by a size code; 0 marks a reserved code
  function automatic logic [5:0] code_shift(input logic [3:0] c);
    case (c)
      4'd0: return 6'd12;
      4'd1: return 6'd14;
      4'd2: return 6'd16;
      4'd3: return 6'd21;
      4'd4: return 6'd25;
      4'd5: return 6'd29;
      4'd6: return 6'd30;
      4'd7: return 6'd34;
      4'd8: return 6'd36;
      4'd9: return 6'd39;
      default: return 6'd0;
    endcase
  endfunction

  // log2 of the region covered by an entry of a given walk level
  function automatic logic [5:0] level_shift(input logic [1:0] l);
    case (l)
      2'd0:    return 6'd30;
      2'd1:    return 6'd21;
      default: return 6'd12;
    endcase
  endfunction
endpackage

// File: rtl/pcri_decode.sv
module pcri_decode import pcri_pkg::*; #(
  parameter int PA_W = 56
) (
  input  logic [63:0]     op,
  input  logic [1:0]      gran,
  input  logic [5:0]      pa_bits,
  input  logic            wide,
  input  logic [1:0]      el,
  output logic            priv_ok,
  output logic            req_ok,
  output logic [PA_W-1:0] base,
  output logic [5:0]      shift
);
  logic [OP_ADDR_W-1:0] lowf;
  logic [3:0]           hi;
  logic [5:0]           gsh, csh;
  logic                 gran_ok, code_ok, aligned, in_range;
  logic                 unused_rsvd;

  assign unused_rsvd = ^op[63:48];
  assign priv_ok     = (el == EL_TOP);
  assign hi          = wide ? op[OP_HI_LSB +: 4] : 4'h0;

  always_comb begin
    gran_ok = 1'b1;
    lowf    = op[OP_ADDR_W-1:0];
    gsh     = 6'd12;
    case (gran_e'(gran))
      GRAN_4K:  gsh = 6'd12;
      GRAN_16K: begin gsh = 6'd14; lowf[1:0] = 2'b00; end
      GRAN_64K: begin gsh = 6'd16; lowf[3:0] = 4'h0;  end
      default:  gran_ok = 1'b0;
    endcase
  end

  assign base    = PA_W'({hi, lowf, {PAGE_SH{1'b0}}});
  assign csh     = code_shift(op[OP_SIZE_LSB +: 4]);
  assign code_ok = (csh != 6'd0);
  assign shift   = (csh < gsh) ? gsh : csh;
  assign aligned = ((base & ~({PA_W{1'b1}} << shift)) == '0);

  always_comb begin
    if (pa_bits >= 6'(PA_W)) in_range = 1'b1;
    else                     in_range = ((base >> pa_bits) == '0);
  end

  assign req_ok = gran_ok && code_ok && aligned && in_range;
endmodule

// File: rtl/pcri_match.sv
module pcri_match import pcri_pkg::*; #(
  parameter int PA_W = 56
) (
  input  logic [PA_W-1:0] base,
  input  logic [5:0]      shift,
  input  logic [PA_W-1:0] tag,
  input  logic [1:0]      level,
  output logic            hit
);
  localparam int EW = PA_W + 1;
  logic [EW-1:0] one, e_lo, e_hi, r_lo, r_hi;
  logic [5:0]    esh;

  assign one  = EW'(1);
  assign esh  = level_shift(level);
  assign e_lo = {1'b0, tag & ({PA_W{1'b1}} << esh)};
  assign e_hi = e_lo + (one << esh) - one;
  assign r_lo = {1'b0, base};
  assign r_hi = r_lo + (one << shift) - one;
  assign hit  = (e_lo <= r_hi) && (r_lo <= e_hi);
endmodule

// File: rtl/pcri_store.sv
module pcri_store #(
  parameter int N_ENT = 8,
  parameter int PA_W  = 56,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [PA_W-1:0]  wr_tag,
  input  logic [1:0]       wr_lvl,
  input  logic [IW-1:0]    rd_idx,
  output logic [PA_W-1:0]  rd_tag,
  output logic [1:0]       rd_lvl,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_idx,
  output logic [N_ENT-1:0] vld
);
  logic [PA_W-1:0] tag_mem [N_ENT];
  logic [1:0]      lvl_mem [N_ENT];

  // tag/level storage without reset, registered read port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      lvl_mem[wr_idx] <= wr_lvl;
    end
    rd_tag <= tag_mem[rd_idx];
    rd_lvl <= lvl_mem[rd_idx];
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst)                                      vld[i] <= 1'b0;
      else if (wr_en && wr_idx == IW'(i))           vld[i] <= 1'b1;
      else if (clr_en && clr_idx == IW'(i))         vld[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/prot_cache_rinv.sv
module prot_cache_rinv import pcri_pkg::*; #(
  parameter int N_ENT = 8,
  parameter int PA_W  = 56,
  localparam int IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int CW   = $clog2(N_ENT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [63:0]      cmd_operand,
  input  logic [1:0]       cfg_granule,
  input  logic [5:0]       cfg_pa_bits,
  input  logic [1:0]       cfg_el,
  input  logic             cfg_wide,
  input  logic             fill_en,
  input  logic [IW-1:0]    fill_idx,
  input  logic [PA_W-1:0]  fill_addr,
  input  logic [1:0]       fill_level,
  output logic             done,
  output logic             undef,
  output logic [N_ENT-1:0] ent_valid
);
  logic            dec_priv_ok, dec_req_ok;
  logic [PA_W-1:0] dec_base, base_q;
  logic [5:0]      dec_shift, shift_q;
  logic            busy, ev_v, done_q, undef_q, hit, acc;
  logic [CW-1:0]   rd_cnt;
  logic [IW-1:0]   ev_idx;
  logic [PA_W-1:0] rd_tag;
  logic [1:0]      rd_lvl;

  assign cmd_ready = !busy;
  assign acc       = cmd_valid && cmd_ready;
  assign done      = done_q;
  assign undef     = undef_q;

  pcri_decode #(.PA_W(PA_W)) u_dec (
    .op(cmd_operand), .gran(cfg_granule), .pa_bits(cfg_pa_bits),
    .wide(cfg_wide), .el(cfg_el), .priv_ok(dec_priv_ok),
    .req_ok(dec_req_ok), .base(dec_base), .shift(dec_shift)
  );

  pcri_store #(.N_ENT(N_ENT), .PA_W(PA_W), .IW(IW)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(fill_en && !busy), .wr_idx(fill_idx),
    .wr_tag(fill_addr), .wr_lvl(fill_level),
    .rd_idx(rd_cnt[IW-1:0]), .rd_tag(rd_tag), .rd_lvl(rd_lvl),
    .clr_en(ev_v && hit), .clr_idx(ev_idx),
    .vld(ent_valid)
  );

  pcri_match #(.PA_W(PA_W)) u_match (
    .base(base_q), .shift(shift_q), .tag(rd_tag), .level(rd_lvl), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      ev_v    <= 1'b0;
      ev_idx  <= '0;
      rd_cnt  <= '0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      base_q  <= '0;
      shift_q <= '0;
    end else begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      ev_v    <= 1'b0;
      if (acc) begin
        if (!dec_priv_ok) begin
          done_q  <= 1'b1;
          undef_q <= 1'b1;
        end else if (!dec_req_ok) begin
          done_q  <= 1'b1;
        end else begin
          busy    <= 1'b1;
          rd_cnt  <= '0;
          base_q  <= dec_base;
          shift_q <= dec_shift;
        end
      end
      if (busy && rd_cnt < CW'(N_ENT)) begin
        ev_v   <= 1'b1;
        ev_idx <= rd_cnt[IW-1:0];
        rd_cnt <= rd_cnt + CW'(1);
      end
      if (ev_v && ev_idx == IW'(N_ENT - 1)) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prot_cache_rinv_chk.sv
module prot_cache_rinv_chk #(
  parameter int N_ENT = 8,
  parameter int IW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cfg_el,
  input logic             fill_en,
  input logic [IW-1:0]    fill_idx,
  input logic             done,
  input logic             undef,
  input logic [N_ENT-1:0] ent_valid,
  input logic             priv_ok,
  input logic             req_ok
);
  logic [IW-1:0] fidx_q;
  logic          acc;
  always_ff @(posedge clk) fidx_q <= fill_idx;
  assign acc = cmd_valid && cmd_ready;

  a_r2_fill_sets: assert property (@(posedge clk) disable iff (rst)
    (fill_en && cmd_ready) |=> ent_valid[fidx_q]);

  a_r3_no_rise_busy: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> ((ent_valid & ~$past(ent_valid)) == '0));

  a_r4_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (acc && priv_ok && req_ok) |=> !cmd_ready);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (done && !acc) |=> !done);

  a_r9_noop_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc && priv_ok && !req_ok && !fill_en) |=> (done && ent_valid == $past(ent_valid)));

  a_r12_refused: assert property (@(posedge clk) disable iff (rst)
    (acc && cfg_el != 2'b11) |=> (undef && done));

  a_r12_undef_has_done: assert property (@(posedge clk) disable iff (rst)
    undef |-> done);
endmodule

bind prot_cache_rinv prot_cache_rinv_chk #(.N_ENT(N_ENT), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cfg_el(cfg_el), .fill_en(fill_en), .fill_idx(fill_idx), .done(done),
  .undef(undef), .ent_valid(ent_valid), .priv_ok(dec_priv_ok), .req_ok(dec_req_ok)
);

// File: tb/prot_cache_rinv_bench.sv
`timescale 1ns/1ps
module prot_cache_rinv_bench;
  localparam int N  = 8;
  localparam int PW = 56;
  localparam int IW = 3;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_ready;
  logic [63:0] cmd_operand = '0;
  logic [1:0] cfg_granule = 0, cfg_el = 2'b11;
  logic [5:0] cfg_pa_bits = 6'd56;
  logic cfg_wide = 0;
  logic fill_en = 0;
  logic [IW-1:0] fill_idx = 0;
  logic [PW-1:0] fill_addr = 0;
  logic [1:0] fill_level = 0;
  logic done, undef;
  logic [N-1:0] ent_valid;

  always #2 clk = ~clk;

  prot_cache_rinv u_prot_cache_rinv (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_operand(cmd_operand), .cfg_granule(cfg_granule), .cfg_pa_bits(cfg_pa_bits),
    .cfg_el(cfg_el), .cfg_wide(cfg_wide), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_addr(fill_addr), .fill_level(fill_level), .done(done), .undef(undef),
    .ent_valid(ent_valid)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    string        tag;
    logic [N-1:0] vld;
    logic         und;
    int           lat;
    int           acc;
  } item_t;
  item_t sb_q[$];

  logic [63:0] m_tag [N];
  logic [1:0]  m_lvl [N];
  logic [N-1:0] m_vld = '0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares each completion against the oldest expectation
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb_q.size() == 0) begin
        check("R4", "unexpected done", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, "ent_valid", 64'(ent_valid), 64'(it.vld));
        check("R12", "undef", 64'(undef), 64'(it.und));
        check("R4", "latency", 64'(cyc - it.acc), 64'(it.lat));
      end
    end
  end

  function automatic int gshift(input logic [1:0] g);
    case (g)
      2'b00: return 12;
      2'b10: return 14;
      2'b01: return 16;
      default: return -1;
    endcase
  endfunction

  function automatic int lshift(input logic [1:0] l);
    if (l == 0) return 30;
    if (l == 1) return 21;
    return 12;
  endfunction

  function automatic int cshift(input logic [3:0] c);
    int t [10] = '{12, 14, 16, 21, 25, 29, 30, 34, 36, 39};
    if (c > 9) return -1;
    return t[c];
  endfunction

  // reference model from the requirements; updates the model slots
  function automatic item_t predict(input string tag, input logic [63:0] op, input logic [1:0] g,
                                    input logic [5:0] pa, input logic [1:0] el, input logic wide);
    item_t it;
    int gs, cs, sh;
    logic [63:0] b, re, lo, hi;
    it.tag = tag; it.und = 0; it.lat = 0; it.acc = 0;
    if (el != 2'b11) begin it.und = 1; it.vld = m_vld; return it; end
    gs = gshift(g); cs = cshift(op[47:44]);
    if (gs < 0 || cs < 0) begin it.vld = m_vld; return it; end
    sh = (cs < gs) ? gs : cs;
    b = ({8'h0, (wide ? op[43:40] : 4'h0), op[39:0], 12'h0}) & ~((64'd1 << gs) - 1);
    if ((b & ((64'd1 << sh) - 1)) != 0) begin it.vld = m_vld; return it; end
    if (pa < 56 && (b >> pa) != 0) begin it.vld = m_vld; return it; end
    re = b + (64'd1 << sh) - 1;
    for (int i = 0; i < N; i++) begin
      lo = m_tag[i] & ~((64'd1 << lshift(m_lvl[i])) - 1);
      hi = lo + (64'd1 << lshift(m_lvl[i])) - 1;
      if (lo <= re && b <= hi) m_vld[i] = 1'b0;
    end
    it.vld = m_vld; it.lat = N + 1;
    return it;
  endfunction

  task automatic send(input string tag, input logic [63:0] op, input logic [1:0] g,
                      input logic [5:0] pa, input logic [1:0] el, input logic wide);
    item_t it;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_operand = op; cfg_granule = g; cfg_pa_bits = pa; cfg_el = el; cfg_wide = wide;
    it = predict(tag, op, g, pa, el, wide);
    @(posedge clk); #1;
    it.acc = cyc;
    sb_q.push_back(it);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_fill(input int idx, input logic [55:0] a, input logic [1:0] l, input bit taken);
    @(negedge clk);
    fill_en = 1; fill_idx = IW'(idx); fill_addr = a; fill_level = l;
    @(posedge clk); #1;
    fill_en = 0;
    if (taken) begin m_tag[idx] = 64'(a); m_lvl[idx] = l; m_vld[idx] = 1'b1; end
  endtask

  task automatic refill();
    do_fill(0, 56'h00_0000_4000_0000, 2'd0, 1);
    do_fill(1, 56'h00_0000_0020_0000, 2'd1, 1);
    do_fill(2, 56'h00_0000_0000_5000, 2'd2, 1);
    do_fill(3, 56'h00_0000_0000_8000, 2'd3, 1);
    do_fill(4, 56'h10_0000_0000_3000, 2'd2, 1);
    do_fill(5, 56'h00_0000_0003_0000, 2'd2, 1);
    do_fill(6, 56'h00_0001_0000_0000, 2'd2, 1);
    do_fill(7, 56'h00_0080_0000_0000, 2'd1, 1);
    @(negedge clk);
    check("R2", "fill sets slots", 64'(ent_valid), 64'(m_vld));
  endtask

  function automatic logic [63:0] mk(input logic [3:0] sz, input logic [3:0] hi4,
                                     input logic [39:0] f, input logic [15:0] junk);
    return {junk, sz, hi4, f};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    check("R4", "watchdog expired", 64'd0, 64'd1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "done in reset", 64'(done), 64'd0);
    check("R1", "undef in reset", 64'(undef), 64'd0);
    check("R1", "ent_valid in reset", 64'(ent_valid), 64'd0);
    check("R1", "cmd_ready in reset", 64'(cmd_ready), 64'd1);
    rst = 0;

    // R5 4KB granule, 4KB range at 0x5000
    refill(); send("R5", mk(4'd0, 4'h0, 40'h5, 16'h0), 2'b00, 6'd56, 2'b11, 0); wait_idle();
    // R5 16KB granule drops operand bits 1:0 -> base 0x4000
    refill(); send("R5", mk(4'd1, 4'h0, 40'h7, 16'h0), 2'b10, 6'd56, 2'b11, 0); wait_idle();
    // R6 size below granule widened to 64KB
    refill(); send("R6", mk(4'd0, 4'h0, 40'h0, 16'h0), 2'b01, 6'd56, 2'b11, 0); wait_idle();
    refill(); send("R6", mk(4'd1, 4'h0, 40'h35, 16'h0), 2'b01, 6'd56, 2'b11, 0); wait_idle();
    // R6 largest code 9
    refill(); send("R6", mk(4'd9, 4'h0, 40'h0, 16'h0), 2'b00, 6'd56, 2'b11, 0); wait_idle();
    // R7 small range inside a 1GB and a 2MB entry
    refill(); send("R7", mk(4'd0, 4'h0, 40'h40001, 16'h0), 2'b00, 6'd56, 2'b11, 0); wait_idle();
    refill(); send("R7", mk(4'd0, 4'h0, 40'h201, 16'h0), 2'b00, 6'd56, 2'b11, 0); wait_idle();
    refill(); send("R7", mk(4'd3, 4'h0, 40'h200, 16'h0), 2'b00, 6'd56, 2'b11, 0); wait_idle();
    // R8 wide bits used / ignored, reserved bits set
    refill(); send("R8", mk(4'd0, 4'h1, 40'h3, 16'hBEEF), 2'b00, 6'd56, 2'b11, 1); wait_idle();
    refill(); send("R8", mk(4'd0, 4'h1, 40'h3, 16'hFFFF), 2'b00, 6'd56, 2'b11, 0); wait_idle();
    // R9 reserved size codes and granule
    refill(); send("R9", mk(4'd10, 4'h0, 40'h5, 16'h0), 2'b00, 6'd56, 2'b11, 0); wait_idle();
    send("R9", mk(4'd15, 4'h0, 40'h0, 16'h0), 2'b00, 6'd56, 2'b11, 0); wait_idle();
    send("R9", mk(4'd0, 4'h0, 40'h5, 16'h0), 2'b11, 6'd56, 2'b11, 0); wait_idle();
    // R10 misaligned 2MB range
    send("R10", mk(4'd3, 4'h0, 40'h1, 16'h0), 2'b00, 6'd56, 2'b11, 0); wait_idle();
    // R11 base above a 32-bit space, then legal within 40 bits
    send("R11", mk(4'd0, 4'h0, 40'h100000, 16'h0), 2'b00, 6'd32, 2'b11, 0); wait_idle();
    send("R11", mk(4'd0, 4'h0, 40'h100000, 16'h0), 2'b00, 6'd40, 2'b11, 0); wait_idle();
    // R12 lower privilege refused
    refill(); send("R12", mk(4'd0, 4'h0, 40'h5, 16'h0), 2'b00, 6'd56, 2'b10, 0); wait_idle();
    send("R12", mk(4'd9, 4'h0, 40'h0, 16'h0), 2'b00, 6'd56, 2'b00, 0); wait_idle();
    // R3 fill during a sweep is ignored and ready stays low
    refill(); send("R3", mk(4'd9, 4'h0, 40'h0, 16'h0), 2'b00, 6'd56, 2'b11, 0);
    @(negedge clk);
    check("R3", "cmd_ready during sweep", 64'(cmd_ready), 64'd0);
    do_fill(2, 56'h00_0000_0000_5000, 2'd2, 0);
    wait_idle();
    check("R3", "ready after sweep", 64'(cmd_ready), 64'd1);

    repeat (4) @(negedge clk);
    check("R4", "queue drained", 64'(sb_q.size()), 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule